// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits on the data side of a 32-bit core, between the register file and a 32-bit memory that is read and written one whole word at a time. For every access it forms the effective address as a base register value plus a signed 16-bit displacement. For stores it works out which byte lanes of the memory word to enable and puts the source data onto those lanes. For loads it takes the word that memory returns, picks out the addressed byte or halfword, and widens it to 32 bits with sign or zero fill.

Lanes are numbered big-endian. Byte address offset 0 within a word is bits 31:24, and offset 3 is bits 7:0. An access that does not fit its natural alignment is reported through an error flag. It is not split into two accesses, and it drives no memory strobe. Memory timing, caches and the register file are outside this block.

Top module: `ls_lane_align`

## Requirements
- R1: One cycle after a valid request, `mem_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. On cycles with no request, `mem_addr` and `mem_wdata` keep their previous values.
- R2: Size code 0 (byte). One cycle after a valid request, `mem_be` has the single bit 3−a set, where a is the effective address modulo 4. `mem_be[i]` gates data bits 8i+7:8i. On a store, `mem_wdata` carries `req_wdata[7:0]` in all four lanes.
- R3: Size code 1 (halfword) with address bit 0 clear. One cycle after the request, `mem_be` is 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. `mem_wdata` carries `req_wdata[15:0]` in both halves.
- R4: Size code 2 (word) with both low address bits clear. One cycle after the request, `mem_be` is 4'b1111 and `mem_wdata` equals `req_wdata`.
- R5: The following requests are misaligned: a halfword with address bit 0 set, a word with either low address bit set, and any request with size code 3. One cycle after such a request, `align_err` is 1, while `mem_we`, `mem_re` and `mem_be` are all 0. No load result follows it.
- R6: An aligned valid request raises `mem_we` for one cycle if `req_store` is 1, and raises `mem_re` for one cycle otherwise. Never are both high at once.
- R7: A byte load returns a result two cycles after the request. In that cycle `ld_valid` is 1 and `ld_data` is the addressed byte of the `mem_rdata` value that was present while `mem_re` was high. The byte is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R8: A halfword load returns a result in the same way. `ld_data` is the addressed halfword (bits 31:16 for address bit 1 = 0, bits 15:0 otherwise), sign-extended or zero-extended according to `req_unsigned`.
- R9: A word load returns the whole `mem_rdata` word in `ld_data`, whatever the value of `req_unsigned`.
- R10: After reset, and one cycle after any cycle with `req_valid` low, `mem_be`, `mem_we`, `mem_re` and `align_err` are 0. When no load completes, `ld_valid` is 0 and `ld_data` holds its last value. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | Load fill: 1 zero-extend, 0 sign-extend |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory in the cycle after the request |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| align_err | output | 1 | Misaligned or reserved-size request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The address, lane enables, write data, strobes and error flag are all due one cycle after the request is sampled. A load result is due two cycles after its request, and it is taken from the `mem_rdata` value driven during the cycle in between. The bench's reference model keeps exactly this two-deep expectation: each clock it turns the current inputs into the next cycle's predicted outputs. It then compares every output on the following falling edge, so each result is checked in the cycle it becomes due and never one cycle early or late.

// File: rtl/ls_lane_pkg.sv
package ls_lane_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned DISPW = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/ls_ea_gen.sv
module ls_ea_gen #(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] disp_i,
    output logic [AW-1:0] ea_o
);
    localparam int unsigned EXTW = AW - OW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXTW{disp_i[OW-1]}}, disp_i};
        ea_o     = base_i + disp_ext;
    end

endmodule

// File: rtl/ls_store_steer.sv
module ls_store_steer
    import ls_lane_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  acc_size_e        size_i,
    input  logic [$clog2(DW/8)-1:0] lo_i,
    input  logic [DW-1:0]    src_i,
    output logic [DW/8-1:0]  be_o,
    output logic [DW-1:0]    wdata_o,
    output logic             misalign_o
);
    localparam int unsigned NL = DW / 8;
    localparam int unsigned LB = $clog2(NL);

    logic [DW/8-1:0] be_raw;

    // misalignment
    always_comb begin
        unique case (size_i)
            SZ_BYTE: misalign_o = 1'b0;
            SZ_HALF: misalign_o = lo_i[0];
            SZ_WORD: misalign_o = (lo_i != '0);
            default: misalign_o = 1'b1;
        endcase
    end

    // lane enables: big-endian lane k sits in be bit NL-1-k
    always_comb begin
        be_raw = '0;
        for (int k = 0; k < NL; k++) begin
            unique case (size_i)
                SZ_BYTE: be_raw[NL-1-k] = (LB'(k) == lo_i);
                SZ_HALF: be_raw[NL-1-k] = (LB'(k >> 1) == (lo_i >> 1));
                default: be_raw[NL-1-k] = 1'b1;
            endcase
        end
        be_o = misalign_o ? '0 : be_raw;
    end

    // replicated write data per lane
    always_comb begin
        wdata_o = '0;
        for (int k = 0; k < NL; k++) begin
            unique case (size_i)
                SZ_BYTE: wdata_o[DW-1-8*k -: 8] = src_i[7:0];
                SZ_HALF: wdata_o[DW-1-8*k -: 8] = (k % 2 == 0) ? src_i[15:8] : src_i[7:0];
                default: wdata_o[DW-1-8*k -: 8] = src_i[DW-1-8*k -: 8];
            endcase
        end
    end

endmodule

// File: rtl/ls_load_extract.sv
module ls_load_extract
    import ls_lane_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  acc_size_e        size_i,
    input  logic             zext_i,
    input  logic [$clog2(DW/8)-1:0] lo_i,
    input  logic [DW-1:0]    word_i,
    output logic [DW-1:0]    data_o
);
    localparam int unsigned NL = DW / 8;
    localparam int unsigned LB = $clog2(NL);

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        fill;

    always_comb begin
        sel_b = '0;
        sel_h = '0;
        for (int k = 0; k < NL; k++) begin
            if (LB'(k) == lo_i) begin
                sel_b = word_i[DW-1-8*k -: 8];
            end
            if ((k % 2 == 0) && (LB'(k >> 1) == (lo_i >> 1))) begin
                sel_h = word_i[DW-1-8*k -: 16];
            end
        end
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                fill   = ~zext_i & sel_b[7];
                data_o = {{(DW-8){fill}}, sel_b};
            end
            SZ_HALF: begin
                fill   = ~zext_i & sel_h[15];
                data_o = {{(DW-16){fill}}, sel_h};
            end
            default: begin
                fill   = 1'b0;
                data_o = word_i;
            end
        endcase
    end

endmodule

// File: rtl/ls_lane_align.sv
module ls_lane_align
    import ls_lane_pkg::*;
#(
    parameter int unsigned DW = XLEN,
    parameter int unsigned OW = DISPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_store,
    input  logic [1:0]      req_size,
    input  logic            req_unsigned,
    input  logic [DW-1:0]   req_base,
    input  logic [OW-1:0]   req_offset,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_we,
    output logic            mem_re,
    output logic            align_err,
    output logic            ld_valid,
    output logic [DW-1:0]   ld_data
);
    localparam int unsigned NL = DW / 8;
    localparam int unsigned LB = $clog2(NL);

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [NL-1:0] be;
        logic [DW-1:0] wdata;
        logic          we;
        logic          re;
        logic          err;
        logic          pend;
        acc_size_e     psize;
        logic          pzext;
        logic [LB-1:0] plo;
        logic          ldv;
        logic [DW-1:0] ldd;
    } lane_st_t;

    lane_st_t st_d, st_q;

    acc_size_e     size_in;
    logic [DW-1:0] ea;
    logic [NL-1:0] be_c;
    logic [DW-1:0] wd_c;
    logic          mis_c;
    logic [DW-1:0] ext_c;

    assign size_in = acc_size_e'(req_size);

    ls_ea_gen #(.AW(DW), .OW(OW)) u_ea (
        .base_i (req_base),
        .disp_i (req_offset),
        .ea_o   (ea)
    );

    ls_store_steer #(.DW(DW)) u_steer (
        .size_i     (size_in),
        .lo_i       (ea[LB-1:0]),
        .src_i      (req_wdata),
        .be_o       (be_c),
        .wdata_o    (wd_c),
        .misalign_o (mis_c)
    );

    ls_load_extract #(.DW(DW)) u_ext (
        .size_i (st_q.psize),
        .zext_i (st_q.pzext),
        .lo_i   (st_q.plo),
        .word_i (mem_rdata),
        .data_o (ext_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.be   = '0;
        st_d.we   = 1'b0;
        st_d.re   = 1'b0;
        st_d.err  = 1'b0;
        st_d.pend = 1'b0;
        st_d.ldv  = 1'b0;

        if (req_valid) begin
            st_d.addr  = ea;
            st_d.wdata = wd_c;
            st_d.err   = mis_c;
            if (!mis_c) begin
                st_d.be   = be_c;
                st_d.we   = req_store;
                st_d.re   = ~req_store;
                st_d.pend = ~req_store;
            end
            st_d.psize = size_in;
            st_d.pzext = req_unsigned;
            st_d.plo   = ea[LB-1:0];
        end

        if (st_q.pend) begin
            st_d.ldv = 1'b1;
            st_d.ldd = ext_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.addr;
    assign mem_be    = st_q.be;
    assign mem_wdata = st_q.wdata;
    assign mem_we    = st_q.we;
    assign mem_re    = st_q.re;
    assign align_err = st_q.err;
    assign ld_valid  = st_q.ldv;
    assign ld_data   = st_q.ldd;

    AST_ERR_BLOCKS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!mem_we && !mem_re && mem_be == '0)); // R5

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R6

    AST_WRITE_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                    || $countones(mem_be) == NL)); // R2

    AST_FULL_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be == '1) |-> (mem_addr[LB-1:0] == '0)); // R4

    AST_HALF_PAIR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0)); // R3

    AST_READ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid); // R7

    AST_RESULT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> $stable(ld_data)); // R10

endmodule

// File: tb/ls_lane_align_bench.sv
module ls_lane_align_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic        align_err;
    logic        ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected state for the cycle being displayed
    logic [31:0] e_addr = '0, e_wd = '0, e_ldd = '0;
    logic [3:0]  e_be = '0;
    logic        e_we = 0, e_re = 0, e_err = 0, e_ldv = 0;
    logic        e_pend = 0, e_pz = 0;
    logic [1:0]  e_psz = 0, e_plo = 0;
    string       t_st = "R9", t_ld = "R9";

    always #5 clk = ~clk;

    ls_lane_align u_ls_lane_align (
        .clk, .rst_n, .req_valid, .req_store, .req_size, .req_unsigned,
        .req_base, .req_offset, .req_wdata, .mem_rdata,
        .mem_addr, .mem_be, .mem_wdata, .mem_we, .mem_re, .align_err,
        .ld_valid, .ld_data
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic st, input logic [1:0] sz,
                        input logic un, input logic [31:0] b,
                        input logic [15:0] o, input logic [31:0] w,
                        input logic [31:0] rd);
        logic [31:0] ea, n_wd, n_ldd, sel;
        logic [3:0]  n_be;
        logic        mis;
        @(negedge clk);
        chk("R1", "mem_addr", mem_addr, e_addr);
        chk(t_st, "mem_be", {28'd0, mem_be}, {28'd0, e_be});
        chk(t_st, "mem_wdata", mem_wdata, e_wd);
        chk("R6", "mem_we", {31'd0, mem_we}, {31'd0, e_we});
        chk("R6", "mem_re", {31'd0, mem_re}, {31'd0, e_re});
        chk("R5", "align_err", {31'd0, align_err}, {31'd0, e_err});
        chk(t_ld, "ld_valid", {31'd0, ld_valid}, {31'd0, e_ldv});
        chk(t_ld, "ld_data", ld_data, e_ldd);

        req_valid = v; req_store = st; req_size = sz; req_unsigned = un;
        req_base = b; req_offset = o; req_wdata = w; mem_rdata = rd;

        // next load result
        n_ldd = e_ldd;
        if (e_pend) begin
            if (e_psz == 2'd0) begin
                sel = (rd >> (8 * (3 - e_plo))) & 32'hFF;
                n_ldd = (!e_pz && sel[7]) ? (sel | 32'hFFFF_FF00) : sel;
                t_ld = "R7";
            end else if (e_psz == 2'd1) begin
                sel = e_plo[1] ? (rd & 32'hFFFF) : (rd >> 16);
                n_ldd = (!e_pz && sel[15]) ? (sel | 32'hFFFF_0000) : sel;
                t_ld = "R8";
            end else begin
                n_ldd = rd;
                t_ld = "R9";
            end
        end else begin
            t_ld = "R10";
        end
        e_ldv = e_pend;
        e_ldd = n_ldd;

        // next address-side outputs
        ea  = b + {{16{o[15]}}, o};
        mis = (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'd0);
        case (sz)
            2'd0:    begin n_be = 4'b1000 >> ea[1:0]; n_wd = {4{w[7:0]}}; end
            2'd1:    begin n_be = ea[1] ? 4'b0011 : 4'b1100; n_wd = {2{w[15:0]}}; end
            default: begin n_be = 4'b1111; n_wd = w; end
        endcase
        if (v) begin
            e_addr = ea;
            e_wd   = n_wd;
            e_err  = mis;
            e_be   = mis ? 4'b0 : n_be;
            e_we   = !mis && st;
            e_re   = !mis && !st;
            e_pend = !mis && !st;
            e_psz  = sz; e_pz = un; e_plo = ea[1:0];
            t_st   = mis ? "R5" : (sz == 2'd0 ? "R2" : (sz == 2'd1 ? "R3" : "R4"));
        end else begin
            e_be = 4'b0; e_we = 0; e_re = 0; e_err = 0; e_pend = 0;
            t_st = "R10";
        end
    endtask

    task automatic idle();
        step(0, 0, 2'd0, 0, 32'h0, 16'h0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9/R10 reset state checked on first step
        idle();
        // R4 word store, aligned, positive offset
        step(1, 1, 2'd2, 0, 32'h0000_1000, 16'h0010, 32'hDEAD_BEEF, 32'h0);
        // R2 byte stores on every lane
        for (int k = 0; k < 4; k++)
            step(1, 1, 2'd0, 0, 32'h0000_2000, 16'(k), 32'h1234_56A5, 32'h0);
        // R3 halfword stores both halves, negative offset wrapping below zero
        step(1, 1, 2'd1, 0, 32'h0000_0002, 16'hFFFC, 32'h0000_C3D2, 32'h0);
        step(1, 1, 2'd1, 0, 32'h0000_3000, 16'h0000, 32'hFFFF_7E81, 32'h0);
        // R5 misaligned half, word, reserved size
        step(1, 1, 2'd1, 0, 32'h0000_4001, 16'h0000, 32'h1111_2222, 32'h0);
        step(1, 0, 2'd2, 0, 32'h0000_4000, 16'h0002, 32'h0, 32'h0);
        step(1, 0, 2'd3, 0, 32'h0000_4000, 16'h0000, 32'h0, 32'h0);
        idle();
        // R7 byte loads all lanes, signed then unsigned
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 2'd0, 0, 32'h0000_5000, 16'(k), 32'h0, 32'h0);
            step(1, 0, 2'd0, 1, 32'h0000_5000, 16'(k), 32'h0, 32'h80F1_7F92);
        end
        // R8 halfword loads
        step(1, 0, 2'd1, 0, 32'h0000_6000, 16'h0000, 32'h0, 32'h80F1_7F92);
        step(1, 0, 2'd1, 1, 32'h0000_6000, 16'h0002, 32'h0, 32'h8001_9AB3);
        step(1, 0, 2'd1, 0, 32'h0000_6000, 16'h0002, 32'h0, 32'h7654_FEDC);
        step(1, 1, 2'd1, 0, 32'h0000_6000, 16'h0002, 32'h0, 32'h1234_8001);
        // R9 word load, unsigned flag ignored
        step(1, 0, 2'd2, 1, 32'hFFFF_FFF0, 16'h0010, 32'h0, 32'h0);
        step(0, 0, 2'd0, 0, 32'h0, 16'h0, 32'h0, 32'h8765_4321);
        idle();
        idle();
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] b;
            b = $urandom;
            if ($urandom % 3 != 0) b[1:0] = 2'b00;
            step(($urandom % 5) != 0, $urandom % 2, 2'($urandom % 4),
                 $urandom % 2, b, 16'($urandom), $urandom, $urandom);
        end
        idle();
        idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule